// File: doc/BRIEF.md
# Switch Egress Idle Packet Generator

This block builds the filler packet that a switch egress port transmits when it has no cell to send. A single strobe starts a packet. The packet then streams out one byte per clock. Beside each byte sits a flag that marks it as a control character, so a downstream 8b/10b encoder can take the stream directly.

A packet is made of eight units of ten bytes each. The first unit is the master unit. It carries the header bytes, a four-bit side-channel value sent twice in one byte, and a flow-control byte. The remaining seven units are slave units and carry only filler. Byte slot 7 of every unit holds a comma character. The channel select chooses which comma is sent.

Every position without a defined field carries the D21.5 data character, so the line keeps toggling. A configuration bit decides whether master byte 2 carries a third header byte or filler. All fields are sampled once, when the start strobe is accepted, and stay fixed until the packet ends.

Top module: `idle_frame_gen`

## Requirements
- R1: After an accepted start, out_valid is high for exactly 80 consecutive cycles, beginning the cycle after the start edge, and out_eop is high only on the 80th byte (unit 7, byte 9).
- R2: Master unit byte 0 equals hdr0 and byte 1 equals hdr1, and byte 6 equals flow_ctl, each with out_k = 0.
- R3: Master byte 2 equals hdr2 when wide_hdr = 1; otherwise it is 0xB5, with out_k = 0 in both cases.
- R4: Byte 7 of every unit is a control character with out_k = 1: 0x3C when chan_hi = 1, 0xBC when chan_hi = 0.
- R5: Master byte 5 equals {side_nib, side_nib}, so bits 7:4 repeat bits 3:0, with out_k = 0.
- R6: Every other byte of the master unit and every byte of the slave units except slot 7 is 0xB5 with out_k = 0.
- R7: All field inputs are captured on the accepted start edge. Changes on those inputs later in the packet do not alter any output byte.
- R8: A start while a packet runs and out_eop is low is ignored. A start on the cycle out_eop is high begins a new packet whose byte 0 follows on the next cycle.
- R9: A synchronous active-high reset, at any time, forces out_valid, out_eop and out_k low and out_byte to 0x00 on the following cycle.
- R10: While out_valid is low, out_byte is 0x00 and out_k is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request one idle packet |
| chan_hi | input | 1 | 1 selects the high channel comma (0x3C), 0 the low (0xBC) |
| wide_hdr | input | 1 | 1 places hdr2 in master byte 2 |
| hdr0 | input | 8 | Header byte for master byte 0 |
| hdr1 | input | 8 | Header byte for master byte 1 |
| hdr2 | input | 8 | Optional header byte for master byte 2 |
| side_nib | input | 4 | Side-channel value, sent doubled in master byte 5 |
| flow_ctl | input | 8 | Flow-control byte for master byte 6 |
| out_byte | output | 8 | Byte on the line this cycle |
| out_k | output | 1 | Marks out_byte as a control character |
| out_valid | output | 1 | A packet byte is present |
| out_eop | output | 1 | Last byte of the packet |

## Verification
The bench aims at slot boundaries. It checks that master-only fields appear in the master unit and never in the slave units, and that the comma lands on slot 7 of each unit and not one slot off. A counter that wraps wrongly would shift every later byte or end the packet early. It also pushes a start into the middle of a packet with new field values: a design that restarts or re-samples would show the new header bytes or jump back to byte 0. It checks the start accepted on the end-of-packet cycle, where a design that needs an idle cycle first would drop the second packet. It also covers a reset in mid-packet, which must end the stream at once.

// File: rtl/idle_pkg.sv
package idle_pkg;

    localparam logic [7:0] FILL_CHAR   = 8'hB5;
    localparam logic [7:0] COMMA_HIGH  = 8'h3C;
    localparam logic [7:0] COMMA_LOW   = 8'hBC;

    localparam int SLOT_HDR0  = 0;
    localparam int SLOT_HDR1  = 1;
    localparam int SLOT_HDR2  = 2;
    localparam int SLOT_SIDE  = 5;
    localparam int SLOT_FLOW  = 6;
    localparam int SLOT_COMMA = 7;

    typedef struct packed {
        logic       chan_hi;
        logic       wide_hdr;
        logic [7:0] hdr0;
        logic [7:0] hdr1;
        logic [7:0] hdr2;
        logic [3:0] side_nib;
        logic [7:0] flow_ctl;
    } idle_fields_t;

    typedef struct packed {
        logic       is_k;
        logic [7:0] value;
    } line_sym_t;

    function automatic line_sym_t pick_symbol(
        input idle_fields_t f,
        input logic         in_master,
        input int           slot
    );
        line_sym_t s;
        s.is_k  = 1'b0;
        s.value = FILL_CHAR;
        if (slot == SLOT_COMMA) begin
            s.is_k  = 1'b1;
            s.value = f.chan_hi ? COMMA_HIGH : COMMA_LOW;
        end else if (in_master) begin
            case (slot)
                SLOT_HDR0: s.value = f.hdr0;
                SLOT_HDR1: s.value = f.hdr1;
                SLOT_HDR2: s.value = f.wide_hdr ? f.hdr2 : FILL_CHAR;
                SLOT_SIDE: s.value = {f.side_nib, f.side_nib};
                SLOT_FLOW: s.value = f.flow_ctl;
                default:   s.value = FILL_CHAR;
            endcase
        end
        return s;
    endfunction

endpackage

// File: rtl/idle_position_ctr.sv
module idle_position_ctr #(
    parameter int UNIT_BYTES = 10,
    parameter int NUM_UNITS  = 8,
    localparam int SLOT_W    = $clog2(UNIT_BYTES),
    localparam int UNIT_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              accept,
    output logic              busy,
    output logic              last,
    output logic [UNIT_W-1:0] unit_idx,
    output logic [SLOT_W-1:0] slot_idx
);

    localparam logic [SLOT_W-1:0] SLOT_MAX = SLOT_W'(UNIT_BYTES - 1);
    localparam logic [UNIT_W-1:0] UNIT_MAX = UNIT_W'(NUM_UNITS - 1);

    logic slot_wrap;

    assign slot_wrap = (slot_idx == SLOT_MAX);
    assign last      = busy && slot_wrap && (unit_idx == UNIT_MAX);
    assign accept    = start && (!busy || last);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            unit_idx <= '0;
            slot_idx <= '0;
        end else if (accept) begin
            busy     <= 1'b1;
            unit_idx <= '0;
            slot_idx <= '0;
        end else if (last) begin
            busy     <= 1'b0;
            unit_idx <= '0;
            slot_idx <= '0;
        end else if (busy) begin
            if (slot_wrap) begin
                slot_idx <= '0;
                unit_idx <= unit_idx + 1'b1;
            end else begin
                slot_idx <= slot_idx + 1'b1;
            end
        end
    end

    // R1
    run_continues_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !last |=> busy);

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !last && start |=> (slot_idx != 0 || unit_idx != 0));

    // R9
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> !busy);

endmodule

// File: rtl/idle_field_latch.sv
module idle_field_latch
    import idle_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         hold,
    input  idle_fields_t fields_in,
    output idle_fields_t fields_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            fields_q <= '0;
        end else if (load) begin
            fields_q <= fields_in;
        end
    end

    // R7
    capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
        hold && !load |=> $stable(fields_q));

endmodule

// File: rtl/idle_symbol_map.sv
module idle_symbol_map
    import idle_pkg::*;
#(
    parameter int SLOT_W = 4,
    parameter int UNIT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  idle_fields_t      fields,
    input  logic              busy,
    input  logic              last,
    input  logic [UNIT_W-1:0] unit_idx,
    input  logic [SLOT_W-1:0] slot_idx,
    output logic [7:0]        sym_byte,
    output logic              sym_k,
    output logic              sym_valid,
    output logic              sym_eop
);

    line_sym_t cur;

    always_comb begin
        cur = pick_symbol(fields, (unit_idx == '0), int'(slot_idx));
        if (!busy) begin
            cur = '0;
        end
    end

    assign sym_byte  = cur.value;
    assign sym_k     = cur.is_k;
    assign sym_valid = busy;
    assign sym_eop   = last;

    // R4
    comma_code_chk: assert property (@(posedge clk) disable iff (rst)
        sym_k |-> (sym_byte == COMMA_HIGH || sym_byte == COMMA_LOW));

    // R6
    k_slot_chk: assert property (@(posedge clk) disable iff (rst)
        sym_valid && (int'(slot_idx) != SLOT_COMMA) |-> !sym_k);

    // R5
    side_dup_chk: assert property (@(posedge clk) disable iff (rst)
        sym_valid && unit_idx == '0 && int'(slot_idx) == SLOT_SIDE
        |-> sym_byte[7:4] == sym_byte[3:0]);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !sym_valid |-> (sym_byte == 8'h00 && !sym_k && !sym_eop));

endmodule

// File: rtl/idle_frame_gen.sv
module idle_frame_gen
    import idle_pkg::*;
#(
    parameter int UNIT_BYTES  = 10,
    parameter int SLAVE_UNITS = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       chan_hi,
    input  logic       wide_hdr,
    input  logic [7:0] hdr0,
    input  logic [7:0] hdr1,
    input  logic [7:0] hdr2,
    input  logic [3:0] side_nib,
    input  logic [7:0] flow_ctl,
    output logic [7:0] out_byte,
    output logic       out_k,
    output logic       out_valid,
    output logic       out_eop
);

    localparam int NUM_UNITS = SLAVE_UNITS + 1;
    localparam int SLOT_W    = $clog2(UNIT_BYTES);
    localparam int UNIT_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;

    logic              accept;
    logic              busy;
    logic              last;
    logic [UNIT_W-1:0] unit_idx;
    logic [SLOT_W-1:0] slot_idx;
    idle_fields_t      fields_in;
    idle_fields_t      fields_q;

    assign fields_in = '{chan_hi:  chan_hi,
                         wide_hdr: wide_hdr,
                         hdr0:     hdr0,
                         hdr1:     hdr1,
                         hdr2:     hdr2,
                         side_nib: side_nib,
                         flow_ctl: flow_ctl};

    idle_position_ctr #(
        .UNIT_BYTES (UNIT_BYTES),
        .NUM_UNITS  (NUM_UNITS)
    ) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .accept   (accept),
        .busy     (busy),
        .last     (last),
        .unit_idx (unit_idx),
        .slot_idx (slot_idx)
    );

    idle_field_latch u_latch (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .hold      (busy),
        .fields_in (fields_in),
        .fields_q  (fields_q)
    );

    idle_symbol_map #(
        .SLOT_W (SLOT_W),
        .UNIT_W (UNIT_W)
    ) u_map (
        .clk       (clk),
        .rst       (rst),
        .fields    (fields_q),
        .busy      (busy),
        .last      (last),
        .unit_idx  (unit_idx),
        .slot_idx  (slot_idx),
        .sym_byte  (out_byte),
        .sym_k     (out_k),
        .sym_valid (out_valid),
        .sym_eop   (out_eop)
    );

    // R1
    eop_in_packet_chk: assert property (@(posedge clk) disable iff (rst)
        out_eop |-> out_valid);

    // R1
    eop_ends_chk: assert property (@(posedge clk) disable iff (rst)
        out_eop && !start |=> !out_valid);

endmodule

// File: tb/idle_frame_gen_bench.sv
module idle_frame_gen_bench;

    localparam int FRAME_LEN = 80;
    localparam int NVEC      = 4;

    // {chan_hi, wide_hdr, hdr0, hdr1, hdr2, side_nib, flow_ctl}
    localparam logic [37:0] VECS [NVEC] = '{
        {1'b1, 1'b1, 8'h12, 8'h34, 8'h56, 4'hA, 8'h9C},
        {1'b0, 1'b0, 8'hF0, 8'h0F, 8'hEE, 4'h3, 8'h00},
        {1'b1, 1'b0, 8'h00, 8'hFF, 8'h77, 4'hF, 8'h81},
        {1'b0, 1'b1, 8'hB5, 8'h3C, 8'hBC, 4'h0, 8'h5A}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       chan_hi = 1'b0;
    logic       wide_hdr = 1'b0;
    logic [7:0] hdr0 = '0, hdr1 = '0, hdr2 = '0, flow_ctl = '0;
    logic [3:0] side_nib = '0;
    logic [7:0] out_byte;
    logic       out_k, out_valid, out_eop;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    idle_frame_gen u_idle_frame_gen (
        .clk(clk), .rst(rst), .start(start), .chan_hi(chan_hi),
        .wide_hdr(wide_hdr), .hdr0(hdr0), .hdr1(hdr1), .hdr2(hdr2),
        .side_nib(side_nib), .flow_ctl(flow_ctl), .out_byte(out_byte),
        .out_k(out_k), .out_valid(out_valid), .out_eop(out_eop)
    );

    task automatic check(input string req, input logic [10:0] act,
                         input logic [10:0] exp, input int pos);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s pos %0d: actual {valid,eop,k,byte}=%h expected %h",
                     req, pos, act, exp);
        end
    endtask

    function automatic logic [8:0] expect_sym(input logic [37:0] v, input int pos);
        int u = pos / 10;
        int b = pos % 10;
        logic ch = v[37];
        logic wd = v[36];
        if (b == 7) return {1'b1, ch ? 8'h3C : 8'hBC};
        if (u != 0) return {1'b0, 8'hB5};
        if (b == 0) return {1'b0, v[35:28]};
        if (b == 1) return {1'b0, v[27:20]};
        if (b == 2) return {1'b0, wd ? v[19:12] : 8'hB5};
        if (b == 5) return {1'b0, v[11:8], v[11:8]};
        if (b == 6) return {1'b0, v[7:0]};
        return {1'b0, 8'hB5};
    endfunction

    function automatic string req_of(input int pos);
        int b = pos % 10;
        if (pos >= 10) return (b == 7) ? "R4" : "R6";
        case (b)
            0, 1, 6: return "R2";
            2:       return "R3";
            5:       return "R5";
            7:       return "R4";
            default: return "R6";
        endcase
    endfunction

    task automatic drive(input logic [37:0] v);
        {chan_hi, wide_hdr, hdr0, hdr1, hdr2, side_nib, flow_ctl} = v;
    endtask

    task automatic launch(input logic [37:0] v);
        @(negedge clk);
        drive(v);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Checks 80 bytes starting at the current negedge.
    task automatic stream(input logic [37:0] v, input int poke_at,
                          input logic [37:0] poke_v, input bit chain,
                          input logic [37:0] chain_v);
        for (int i = 0; i < FRAME_LEN; i++) begin
            check((i == poke_at + 1) ? "R8" : req_of(i),
                  {out_valid, out_eop, out_k, out_byte},
                  {1'b1, (i == FRAME_LEN - 1), expect_sym(v, i)}, i);
            if (i == poke_at) begin
                drive(poke_v);
                start = 1'b1;
            end else if (chain && i == FRAME_LEN - 1) begin
                drive(chain_v);
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (i < FRAME_LEN - 1) @(negedge clk);
        end
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 R10: reset state
        check("R9", {out_valid, out_eop, out_k, out_byte}, 11'h0, -1);
        rst = 1'b0;
        @(negedge clk);
        check("R10", {out_valid, out_eop, out_k, out_byte}, 11'h0, -1);

        // Table walk: R1..R6
        for (int n = 0; n < NVEC; n++) begin
            launch(VECS[n]);
            stream(VECS[n], -1, '0, 1'b0, '0);
            @(negedge clk);
            check("R1", {out_valid, out_eop, out_k, out_byte}, 11'h0, FRAME_LEN);
        end

        // R7 R8: mid-packet start with new fields is ignored
        launch(VECS[0]);
        stream(VECS[0], 23, VECS[1], 1'b0, '0);
        @(negedge clk);
        check("R8", {out_valid, out_eop, out_k, out_byte}, 11'h0, FRAME_LEN);

        // R7: inputs wander without start
        launch(VECS[2]);
        drive(VECS[3]);
        stream(VECS[2], -1, '0, 1'b0, '0);
        @(negedge clk);

        // R8: start on end-of-packet cycle chains a packet
        launch(VECS[1]);
        stream(VECS[1], -1, '0, 1'b1, VECS[3]);
        @(negedge clk);
        start = 1'b0;
        stream(VECS[3], -1, '0, 1'b0, '0);
        @(negedge clk);
        check("R8", {out_valid, out_eop, out_k, out_byte}, 11'h0, FRAME_LEN);

        // R9: reset in mid-packet aborts
        launch(VECS[0]);
        repeat (30) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R9", {out_valid, out_eop, out_k, out_byte}, 11'h0, 30);
        rst = 1'b0;
        @(negedge clk);
        check("R10", {out_valid, out_eop, out_k, out_byte}, 11'h0, 31);

        // R1: fresh packet after abort starts at byte 0
        launch(VECS[2]);
        stream(VECS[2], -1, '0, 1'b0, '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule